// File: doc/BRIEF.md
# Watchdog Timer with Guarded Shutdown

This block is a watchdog timer that runs on its own slow clock. Once enabled it counts clock cycles, and software must restart it with a kick strobe before the count reaches the selected time-out. If no kick arrives in time, the block asserts a reset-request pulse for one cycle, restarts its count and sets a sticky reset-cause flag. System software reads that flag after start-up to find out why the chip restarted.

The time-out is chosen from eight lengths. Each is twice the one before, and the shortest is `2**BASE_LOG2` cycles. A single control-register write port sets the select field, the enable bit and a turn-off permission bit. Turning the watchdog off is guarded: a write that clears the enable bit only takes effect when the same write also sets the turn-off permission bit. The permission bit expires by itself shortly after it is set, so a stray write cannot stop the watchdog.

The control path is a three-state machine. `ST_OFF` is idle, `ST_RUN` is counting and `ST_BITE` is the one-cycle reset pulse. These are the transitions:
- OFF→RUN on a write with the enable bit set.
- RUN→BITE when the count reaches its terminal value and no kick or select change arrives in the same cycle.
- BITE→RUN always, unless a guarded disable arrives in that cycle.
- RUN→OFF and BITE→OFF on a guarded disable.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset (`por_n` low) the control readback is 0, the reset-cause flag is 0 and `wdt_reset_req` is 0.
- R2: Control field layout: bits [2:0] select, bit 3 enable, bit 4 turn-off permission. Once enabled, `wdt_reset_req` rises exactly `2**(BASE_LOG2+select)` clock cycles after the enabling write.
- R3: `wdt_reset_req` is high for one clock cycle only, and the count restarts with it, so an unattended watchdog fires again every time-out period.
- R4: A kick clears the count, and the next request comes one full time-out period after the kick.
- R5: A control write that changes the select field clears the count. A write that keeps the same select value does not clear it.
- R6: A write with enable 0 and turn-off permission 0 leaves the watchdog enabled and its time-out undisturbed.
- R7: A write with enable 0 and turn-off permission 1 stops the watchdog, and no request follows.
- R8: Writing 1 to the turn-off permission bit sets it in the readback for exactly 4 cycles (`TOE_HOLD`), after which hardware clears it.
- R9: Readback bits [7:5] are always 0, whatever was written to them.
- R10: A reset request sets the reset-cause flag. Writing 0 to the flag clears it, writing 1 leaves it unchanged, and a power-on reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register readback |
| kick | input | 1 | Software restart strobe |
| flag_we | input | 1 | Reset-cause flag write strobe |
| flag_wdata | input | 1 | Reset-cause flag write value (only 0 acts) |
| wdt_reset_req | output | 1 | One-cycle reset request |
| wdt_flag | output | 1 | Reset-cause flag |

## Verification
The bench builds the block with `BASE_LOG2 = 4` and keeps `SEL_W = 3` and `TOE_HOLD = 4`. With these values the time-outs run from 16 to 2048 cycles. This keeps even the longest select value within a short run, so its exact expiry edge can be checked. The short periods also allow kicks, select changes and guarded-disable attempts to be placed at precise cycles inside a single period, where a cleared or uncleared count gives a visibly different expiry time.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_BITE = 2'd2
    } wdt_state_e;

endpackage

// File: rtl/wdt_toe_window.sv
module wdt_toe_window #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_val,
    output logic toe_o
);
    localparam int HOLD_W = $clog2(HOLD + 1);
    localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD - 1);

    logic [HOLD_W-1:0] hold_q;
    logic              toe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toe_q  <= 1'b0;
            hold_q <= '0;
        end else if (load) begin
            toe_q  <= load_val;
            hold_q <= load_val ? HOLD_INIT : '0;
        end else if (toe_q) begin
            if (hold_q != '0) begin
                hold_q <= hold_q - 1'b1;
            end else begin
                toe_q <= 1'b0;
            end
        end
    end

    assign toe_o = toe_q;

    AST_TOE_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (toe_q && hold_q == '0 && !load) |=> !toe_q); // R8

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int BASE_LOG2 = 14,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             term
);
    localparam int MAXSH = (1 << SEL_W) - 1;
    localparam int CNT_W = BASE_LOG2 + MAXSH;
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = ALL_ONES >> (SEL_W'(MAXSH) - sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign term = run && (cnt_q == limit);

    AST_CLEARED_NO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !term); // R4

endmodule

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic dis_ok,
    input  logic restart,
    input  logic term,
    output logic running,
    output logic fire,
    output logic stop,
    output logic req
);
    wdt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_set) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (dis_ok)                 state_d = ST_OFF;
                else if (term && !restart)  state_d = ST_BITE;
            end
            ST_BITE: begin
                state_d = dis_ok ? ST_OFF : ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        running = (state_q != ST_OFF);
        req     = (state_q == ST_BITE);
        fire    = (state_q == ST_RUN) && (state_d == ST_BITE);
        stop    = (state_d == ST_OFF);
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req); // R3

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int BASE_LOG2 = 14,
    parameter int SEL_W     = 3,
    parameter int TOE_HOLD  = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              kick,
    input  logic              flag_we,
    input  logic              flag_wdata,
    output logic              wdt_reset_req,
    output logic              wdt_flag
);
    localparam int EN_POS  = SEL_W;
    localparam int TOE_POS = SEL_W + 1;

    logic [SEL_W-1:0] sel_q;
    logic             sel_chg, en_set, dis_ok, restart;
    logic             term, running, fire, stop, req;
    logic             toe;
    logic             flag_q;

    always_comb begin
        en_set  = ctrl_we && ctrl_wdata[EN_POS];
        dis_ok  = ctrl_we && !ctrl_wdata[EN_POS] && ctrl_wdata[TOE_POS];
        sel_chg = ctrl_we && (ctrl_wdata[SEL_W-1:0] != sel_q);
        restart = kick || sel_chg;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sel_q <= '0;
        end else if (ctrl_we) begin
            sel_q <= ctrl_wdata[SEL_W-1:0];
        end
    end

    wdt_toe_window #(.HOLD(TOE_HOLD)) toe_i (
        .clk      (clk),
        .rst_n    (por_n),
        .load     (ctrl_we),
        .load_val (ctrl_wdata[TOE_POS]),
        .toe_o    (toe)
    );

    wdt_tick_counter #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) cnt_i (
        .clk   (clk),
        .rst_n (por_n),
        .run   (running),
        .clr   (restart || fire || stop),
        .sel   (sel_q),
        .term  (term)
    );

    wdt_ctrl_fsm fsm_i (
        .clk     (clk),
        .rst_n   (por_n),
        .en_set  (en_set),
        .dis_ok  (dis_ok),
        .restart (restart),
        .term    (term),
        .running (running),
        .fire    (fire),
        .stop    (stop),
        .req     (req)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (fire) begin
            flag_q <= 1'b1;
        end else if (flag_we && !flag_wdata) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_rdata              = '0;
        ctrl_rdata[SEL_W-1:0]   = sel_q;
        ctrl_rdata[EN_POS]      = running;
        ctrl_rdata[TOE_POS]     = toe;
    end

    assign wdt_reset_req = req;
    assign wdt_flag      = flag_q;

    AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!por_n)
        wdt_reset_req |-> wdt_flag); // R10

    AST_GUARD_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_rdata[EN_POS] && ctrl_we && !ctrl_wdata[EN_POS] && !ctrl_wdata[TOE_POS])
        |=> ctrl_rdata[EN_POS]); // R6

    AST_KICK_NO_BITE: assert property (@(posedge clk) disable iff (!por_n)
        kick |=> !wdt_reset_req); // R4

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!por_n)
        (!ctrl_rdata[EN_POS] && !(ctrl_we && ctrl_wdata[EN_POS])) |=> !wdt_reset_req); // R7

endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;

    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       kick = 1'b0;
    logic       flag_we = 1'b0;
    logic       flag_wdata = 1'b0;
    logic       wdt_reset_req;
    logic       wdt_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_guard #(.BASE_LOG2(BASE), .SEL_W(3), .TOE_HOLD(4)) dut_i (
        .clk           (clk),
        .por_n         (por_n),
        .ctrl_we       (ctrl_we),
        .ctrl_wdata    (ctrl_wdata),
        .ctrl_rdata    (ctrl_rdata),
        .kick          (kick),
        .flag_we       (flag_we),
        .flag_wdata    (flag_wdata),
        .wdt_reset_req (wdt_reset_req),
        .wdt_flag      (wdt_flag)
    );

    function automatic int period(input int sel);
        return 1 << (BASE + sel);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = d;
        @(negedge clk);
        ctrl_we = 1'b0; ctrl_wdata = '0;
    endtask

    task automatic do_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    task automatic wr_flag(input logic v);
        @(negedge clk); flag_we = 1'b1; flag_wdata = v;
        @(negedge clk); flag_we = 1'b0; flag_wdata = 1'b0;
    endtask

    task automatic stop_wdt();
        wr_ctrl(8'h10);
        step(6);
        wr_flag(1'b0);
    endtask

    task automatic t_reset();
        check("R1 ctrl readback", ctrl_rdata, 8'h00);
        check("R1 flag", wdt_flag, 1'b0);
        check("R1 req", wdt_reset_req, 1'b0);
    endtask

    task automatic t_timeout(input int sel);
        int p = period(sel);
        wr_ctrl(8'h08 | 8'(sel));
        step(p - 1);
        check("R2 no req before expiry", wdt_reset_req, 1'b0);
        step(1);
        check("R2 req at expiry", wdt_reset_req, 1'b1);
        check("R10 flag set by req", wdt_flag, 1'b1);
        step(1);
        check("R3 pulse one cycle", wdt_reset_req, 1'b0);
        step(p - 2);
        check("R3 no req before second expiry", wdt_reset_req, 1'b0);
        step(1);
        check("R3 second req after one period", wdt_reset_req, 1'b1);
        step(1);
    endtask

    task automatic t_flag();
        wr_flag(1'b1);
        check("R10 writing 1 keeps flag", wdt_flag, 1'b1);
        wr_flag(1'b0);
        check("R10 writing 0 clears flag", wdt_flag, 1'b0);
    endtask

    task automatic t_kick();
        wr_ctrl(8'h08);
        step(10);
        do_kick();
        step(15);
        check("R4 no req one cycle before kicked expiry", wdt_reset_req, 1'b0);
        step(1);
        check("R4 req one period after kick", wdt_reset_req, 1'b1);
        stop_wdt();
    endtask

    task automatic t_sel_change();
        wr_ctrl(8'h09);
        step(20);
        wr_ctrl(8'h08);
        step(15);
        check("R5 sel change clears count (early)", wdt_reset_req, 1'b0);
        step(1);
        check("R5 sel change clears count (expiry)", wdt_reset_req, 1'b1);
        stop_wdt();
        wr_ctrl(8'h08);
        step(9);
        wr_ctrl(8'h08);
        step(4);
        check("R5 same sel keeps count (early)", wdt_reset_req, 1'b0);
        step(1);
        check("R5 same sel keeps count (expiry)", wdt_reset_req, 1'b1);
        stop_wdt();
    endtask

    task automatic t_guard();
        wr_ctrl(8'h08);
        wr_ctrl(8'h00);
        check("R6 unguarded disable ignored", ctrl_rdata[3], 1'b1);
        step(13);
        check("R6 time-out undisturbed (early)", wdt_reset_req, 1'b0);
        step(1);
        check("R6 time-out undisturbed (expiry)", wdt_reset_req, 1'b1);
        stop_wdt();
    endtask

    task automatic t_disable();
        int seen = 0;
        wr_ctrl(8'h08);
        step(5);
        wr_ctrl(8'h10);
        check("R7 guarded disable clears enable", ctrl_rdata[3], 1'b0);
        check("R8 permission bit set", ctrl_rdata[4], 1'b1);
        step(3);
        check("R8 permission bit still set at cycle 4", ctrl_rdata[4], 1'b1);
        step(1);
        check("R8 permission bit self-cleared", ctrl_rdata[4], 1'b0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (wdt_reset_req) seen++;
        end
        check("R7 no request after disable", 32'(seen), 32'd0);
    endtask

    task automatic t_reserved();
        wr_ctrl(8'hE2);
        check("R9 reserved bits read zero", ctrl_rdata, 8'h02);
        wr_ctrl(8'hF8);
        check("R9 reserved bits read zero while on", ctrl_rdata[7:5], 3'b000);
        stop_wdt();
        wr_ctrl(8'h00);
    endtask

    task automatic t_por();
        wr_ctrl(8'h08);
        step(16);
        check("R10 flag before power-on reset", wdt_flag, 1'b1);
        por_n = 1'b0;
        step(2);
        check("R10 flag cleared by power-on reset", wdt_flag, 1'b0);
        check("R1 readback after power-on reset", ctrl_rdata, 8'h00);
        por_n = 1'b1;
        step(2);
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        step(3);
        t_reset();
        por_n = 1'b1;
        step(2);
        t_reset();
        t_timeout(0);
        t_flag();
        stop_wdt();
        t_timeout(2);
        stop_wdt();
        t_timeout(7);
        stop_wdt();
        t_kick();
        t_sel_change();
        t_guard();
        t_disable();
        t_reserved();
        t_por();
        done = 1'b1;
        finish_sim();
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            finish_sim();
        end
    end

endmodule